// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit core's execute stage and a byte-addressed memory that keeps data most-significant-byte first. From an opcode, a base register and a 16-bit signed offset it forms the effective address and checks it against the alignment rule of the access size. For loads it takes the memory read word, picks the addressed byte or halfword, and extends it to 32 bits. For the two halfword-merge loads it combines half of the memory word with half of the old destination value. For stores it places the store data in the correct byte lanes and raises the matching byte write enables.

The block is purely combinational. The core presents the operands and the read word for the addressed word in the same cycle, and it takes the load result, the lanes and the address-error flag back in that cycle. A misaligned access is never split into two accesses. It is refused: the error flag rises, no lane is enabled and the destination keeps its old value.

Top module: `be_mem_aligner`

## Requirements
- R1: Opcode 0x20 loads one byte sign-extended and 0x24 loads one byte zero-extended. Address bits [1:0] choose byte lane k, which is memRdata[31-8k:24-8k], so lane 0 is the most significant byte. Bytes need no alignment.
- R2: Opcode 0x21 loads a halfword sign-extended and 0x25 loads one zero-extended. Address bit 1 = 0 takes memRdata[31:16] and bit 1 = 1 takes memRdata[15:0]. An odd address is an address error.
- R3: Opcode 0x23 returns the whole memRdata word. Address bits [1:0] must be 00, or it is an address error.
- R4: Opcode 0x0F returns the offset shifted left by 16 with the low 16 bits zero. It never raises an address error, whatever the address, and it enables no lane.
- R5: Opcode 0x22 needs address bits [1:0] = 00 and returns {memRdata[31:16], destOld[15:0]}. Any other address is an address error.
- R6: Opcode 0x26 needs address bits [1:0] = 11 and returns {destOld[31:16], memRdata[15:0]}. Its word address is always bits [31:2] of (effective address - 3). Any other address is an address error.
- R7: Opcode 0x28 stores storeData[7:0] into the lane chosen by address bits [1:0]. byteEn bit k enables lane k, so byteEn = 1 << addr[1:0]. All other bits of wrData are zero.
- R8: Opcode 0x29 stores storeData[15:0] as a halfword. Address bit 1 = 0 gives lanes 0-1 (byteEn = 4'b0011, data in wrData[31:16]). Address bit 1 = 1 gives lanes 2-3 (byteEn = 4'b1100, data in wrData[15:0]). An odd address is an address error.
- R9: Opcode 0x2B stores the whole storeData word with byteEn = 4'b1111. Address bits [1:0] must be 00, or it is an address error.
- R10: On an address error, addrErr is 1, byteEn and wrData are zero, and loadResult equals destOld.
- R11: The effective address is baseVal plus the sign-extended offset, with carries and borrows across all bits. Except for R6, wordAddr is bits [31:2] of that address.
- R12: For any opcode that is not a load, loadResult equals destOld. For any opcode that is not a store, byteEn and wrData are zero. For any opcode not listed above, addrErr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 6 | Primary opcode of the access |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed offset (upper immediate for 0x0F) |
| storeData | input | 32 | Register value to store |
| destOld | input | 32 | Present value of the destination register |
| memRdata | input | 32 | Memory word read at wordAddr |
| wordAddr | output | 30 | Word address sent to memory |
| byteEn | output | 4 | Byte write enables, bit k for lane k |
| wrData | output | 32 | Store data placed in its lanes |
| loadResult | output | 32 | New destination value |
| addrErr | output | 1 | Alignment fault |

## Verification
Alignment checking and result forming happen in the same cycle. A faulting access must therefore raise addrErr and, in that same cycle, hold back every lane enable and return destOld in place of the extracted or merged data. Vectors drive each sized access at addresses one or two bytes off its legal alignment. Some of those addresses come from negative offsets that borrow into the base, so the alignment decision depends on the adder's low bits. Each such vector is judged on the flag, the lanes, the write data and the result together, compared against values worked out by hand.

// File: rtl/dalign_pkg.sv
package dalign_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;

  localparam logic [OP_W-1:0] OP_LD_BYTE_S = 6'h20;
  localparam logic [OP_W-1:0] OP_LD_HALF_S = 6'h21;
  localparam logic [OP_W-1:0] OP_LD_MRG_HI = 6'h22;
  localparam logic [OP_W-1:0] OP_LD_WORD   = 6'h23;
  localparam logic [OP_W-1:0] OP_LD_BYTE_U = 6'h24;
  localparam logic [OP_W-1:0] OP_LD_HALF_U = 6'h25;
  localparam logic [OP_W-1:0] OP_LD_MRG_LO = 6'h26;
  localparam logic [OP_W-1:0] OP_LD_UPPER  = 6'h0F;
  localparam logic [OP_W-1:0] OP_ST_BYTE   = 6'h28;
  localparam logic [OP_W-1:0] OP_ST_HALF   = 6'h29;
  localparam logic [OP_W-1:0] OP_ST_WORD   = 6'h2B;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic     doLoad;
    logic     doStore;
    accSize_e size;
    logic     signExt;
    logic     keepOldLo;
    logic     keepOldHi;
    logic     upperImm;
    logic     backThree;
    logic     fault;
  } ctrlStrobes_t;

endpackage

// File: rtl/dalign_ctrl.sv
module dalign_ctrl
  import dalign_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic [1:0]      eaLow,
  output ctrlStrobes_t    strobes
);

  logic needEven;
  logic needWord;
  logic needTop;

  always_comb begin
    strobes  = '0;
    needEven = 1'b0;
    needWord = 1'b0;
    needTop  = 1'b0;
    case (opCode)
      OP_LD_BYTE_S: begin
        strobes.doLoad  = 1'b1;
        strobes.size    = SZ_BYTE;
        strobes.signExt = 1'b1;
      end
      OP_LD_BYTE_U: begin
        strobes.doLoad = 1'b1;
        strobes.size   = SZ_BYTE;
      end
      OP_LD_HALF_S: begin
        strobes.doLoad  = 1'b1;
        strobes.size    = SZ_HALF;
        strobes.signExt = 1'b1;
        needEven        = 1'b1;
      end
      OP_LD_HALF_U: begin
        strobes.doLoad = 1'b1;
        strobes.size   = SZ_HALF;
        needEven       = 1'b1;
      end
      OP_LD_WORD: begin
        strobes.doLoad = 1'b1;
        strobes.size   = SZ_WORD;
        needWord       = 1'b1;
      end
      OP_LD_MRG_HI: begin
        strobes.doLoad    = 1'b1;
        strobes.size      = SZ_WORD;
        strobes.keepOldLo = 1'b1;
        needWord          = 1'b1;
      end
      OP_LD_MRG_LO: begin
        strobes.doLoad    = 1'b1;
        strobes.size      = SZ_WORD;
        strobes.keepOldHi = 1'b1;
        strobes.backThree = 1'b1;
        needTop           = 1'b1;
      end
      OP_LD_UPPER: begin
        strobes.doLoad   = 1'b1;
        strobes.upperImm = 1'b1;
      end
      OP_ST_BYTE: begin
        strobes.doStore = 1'b1;
        strobes.size    = SZ_BYTE;
      end
      OP_ST_HALF: begin
        strobes.doStore = 1'b1;
        strobes.size    = SZ_HALF;
        needEven        = 1'b1;
      end
      OP_ST_WORD: begin
        strobes.doStore = 1'b1;
        strobes.size    = SZ_WORD;
        needWord        = 1'b1;
      end
      default: strobes = '0;
    endcase
    strobes.fault = (needEven && eaLow[0])
                  || (needWord && (eaLow != 2'b00))
                  || (needTop && (eaLow != 2'b11));
  end

endmodule

// File: rtl/dalign_dpath.sv
module dalign_dpath
  import dalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] destOld,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        eaLow,
  output logic [ADDR_W-3:0] wordAddr,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadResult
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] effAddr;
  logic              borrowWord;
  logic [7:0]        rdLane [LANES];
  logic [7:0]        pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [DATA_W-1:0] sizedLoad;
  logic [LANES-1:0]  laneMask;
  logic              storeLive;

  assign effAddr = baseVal + {{(ADDR_W-IMM_W){offsetImm[IMM_W-1]}}, offsetImm};
  assign eaLow   = effAddr[1:0];

  // stepping back three bytes leaves the word unchanged only when the low bits are 11
  assign borrowWord = strobes.backThree && (effAddr[1:0] != 2'b11);
  assign wordAddr   = effAddr[ADDR_W-1:2] - {{(ADDR_W-3){1'b0}}, borrowWord};

  for (genvar k = 0; k < LANES; k++) begin : gRdLane
    assign rdLane[k] = memRdata[DATA_W-1-8*k -: 8];
  end

  assign pickByte = rdLane[effAddr[1:0]];
  assign pickHalf = effAddr[1] ? memRdata[HALF_W-1:0] : memRdata[DATA_W-1:HALF_W];

  always_comb begin
    case (strobes.size)
      SZ_BYTE: sizedLoad = {{(DATA_W-8){strobes.signExt & pickByte[7]}}, pickByte};
      SZ_HALF: sizedLoad = {{HALF_W{strobes.signExt & pickHalf[HALF_W-1]}}, pickHalf};
      default: sizedLoad = memRdata;
    endcase
  end

  always_comb begin
    if (!strobes.doLoad || strobes.fault) begin
      loadResult = destOld;
    end else if (strobes.upperImm) begin
      loadResult = {offsetImm, {(DATA_W-IMM_W){1'b0}}};
    end else if (strobes.keepOldLo) begin
      loadResult = {memRdata[DATA_W-1:HALF_W], destOld[HALF_W-1:0]};
    end else if (strobes.keepOldHi) begin
      loadResult = {destOld[DATA_W-1:HALF_W], memRdata[HALF_W-1:0]};
    end else begin
      loadResult = sizedLoad;
    end
  end

  assign storeLive = strobes.doStore && !strobes.fault;

  always_comb begin
    case (strobes.size)
      SZ_BYTE: laneMask = LANES'(1) << effAddr[1:0];
      SZ_HALF: laneMask = effAddr[1] ? 4'b1100 : 4'b0011;
      default: laneMask = '1;
    endcase
  end

  assign byteEn = storeLive ? laneMask : '0;

  for (genvar k = 0; k < LANES; k++) begin : gWrLane
    logic [7:0] laneVal;
    always_comb begin
      case (strobes.size)
        SZ_BYTE: laneVal = storeData[7:0];
        SZ_HALF: laneVal = (k % 2 == 0) ? storeData[15:8] : storeData[7:0];
        default: laneVal = storeData[DATA_W-1-8*k -: 8];
      endcase
    end
    assign wrData[DATA_W-1-8*k -: 8] = byteEn[k] ? laneVal : 8'h00;
  end

endmodule

// File: rtl/be_mem_aligner.sv
module be_mem_aligner
  import dalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] destOld,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-3:0] wordAddr,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadResult,
  output logic              addrErr
);

  ctrlStrobes_t strobes;
  logic [1:0]   eaLow;

  dalign_ctrl uCtrl (
    .opCode  (opCode),
    .eaLow   (eaLow),
    .strobes (strobes)
  );

  dalign_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .strobes    (strobes),
    .baseVal    (baseVal),
    .offsetImm  (offsetImm),
    .storeData  (storeData),
    .destOld    (destOld),
    .memRdata   (memRdata),
    .eaLow      (eaLow),
    .wordAddr   (wordAddr),
    .byteEn     (byteEn),
    .wrData     (wrData),
    .loadResult (loadResult)
  );

  assign addrErr = strobes.fault;

endmodule

// File: rtl/be_mem_aligner_chk.sv
module be_mem_aligner_chk
  import dalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic [OP_W-1:0]   opCode,
  input logic [ADDR_W-3:0] wordAddr,
  input logic [LANES-1:0]  byteEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] destOld,
  input logic [DATA_W-1:0] loadResult,
  input logic              addrErr
);

  logic isStoreOp;
  assign isStoreOp = (opCode == OP_ST_BYTE) || (opCode == OP_ST_HALF) || (opCode == OP_ST_WORD);

  always_comb begin
    AST_FAULT_NO_LANES: assert (!addrErr || (byteEn == '0 && wrData == '0)); // R10
    AST_FAULT_KEEP_DEST: assert (!addrErr || loadResult == destOld); // R10
    AST_NONSTORE_NO_LANES: assert (isStoreOp || byteEn == '0); // R12
    AST_STORE_KEEP_DEST: assert (!isStoreOp || loadResult == destOld); // R12
    AST_UPPER_NO_FAULT: assert (opCode != OP_LD_UPPER || !addrErr); // R4
    AST_BYTE_STORE_ONE_LANE: assert (opCode != OP_ST_BYTE || $onehot(byteEn)); // R7
    AST_HALF_STORE_PAIR: assert (opCode != OP_ST_HALF || addrErr || byteEn == 4'b0011 || byteEn == 4'b1100); // R8
    AST_WORD_STORE_ALL: assert (opCode != OP_ST_WORD || addrErr || byteEn == 4'b1111); // R9
    AST_MERGE_HI_KEEPS_LOW: assert (opCode != OP_LD_MRG_HI || loadResult[15:0] == destOld[15:0]); // R5
    AST_MERGE_LO_KEEPS_HIGH: assert (opCode != OP_LD_MRG_LO || loadResult[31:16] == destOld[31:16]); // R6
    AST_ADDR_KNOWN: assert (!$isunknown(wordAddr)); // R11
  end

endmodule

bind be_mem_aligner be_mem_aligner_chk #(.ADDR_W(ADDR_W)) uChk (
  .opCode     (opCode),
  .wordAddr   (wordAddr),
  .byteEn     (byteEn),
  .wrData     (wrData),
  .destOld    (destOld),
  .loadResult (loadResult),
  .addrErr    (addrErr)
);

// File: tb/tb_be_mem_aligner.sv
`timescale 1ns/1ps
module tb_be_mem_aligner;

  localparam logic [31:0] MEMW = 32'hF17E_932C;
  localparam logic [31:0] OLDV = 32'hBABA_CDCD;
  localparam logic [31:0] STV  = 32'h1234_56A9;

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic        err;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] res;
    logic [29:0] wa;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  6'h20, 32'h100, 16'h0000, 1'b0, 4'h0, 32'h0, 32'hFFFF_FFF1, 30'h40},      // R1
    '{4'd1,  6'h24, 32'h100, 16'h0003, 1'b0, 4'h0, 32'h0, 32'h0000_002C, 30'h40},      // R1
    '{4'd1,  6'h20, 32'h100, 16'h0001, 1'b0, 4'h0, 32'h0, 32'h0000_007E, 30'h40},      // R1
    '{4'd1,  6'h24, 32'h100, 16'h0002, 1'b0, 4'h0, 32'h0, 32'h0000_0093, 30'h40},      // R1
    '{4'd2,  6'h21, 32'h200, 16'h0000, 1'b0, 4'h0, 32'h0, 32'hFFFF_F17E, 30'h80},      // R2
    '{4'd2,  6'h25, 32'h200, 16'h0002, 1'b0, 4'h0, 32'h0, 32'h0000_932C, 30'h80},      // R2
    '{4'd2,  6'h21, 32'h200, 16'h0002, 1'b0, 4'h0, 32'h0, 32'hFFFF_932C, 30'h80},      // R2
    '{4'd10, 6'h21, 32'h200, 16'h0001, 1'b1, 4'h0, 32'h0, OLDV,          30'h80},      // R10
    '{4'd3,  6'h23, 32'h300, 16'h0000, 1'b0, 4'h0, 32'h0, MEMW,          30'hC0},      // R3
    '{4'd10, 6'h23, 32'h300, 16'h0002, 1'b1, 4'h0, 32'h0, OLDV,          30'hC0},      // R10
    '{4'd11, 6'h23, 32'h310, 16'hFFFC, 1'b0, 4'h0, 32'h0, MEMW,          30'hC3},      // R11
    '{4'd4,  6'h0F, 32'h0,   16'h8421, 1'b0, 4'h0, 32'h0, 32'h8421_0000, 30'h3FFFE108},// R4
    '{4'd5,  6'h22, 32'h400, 16'h0000, 1'b0, 4'h0, 32'h0, 32'hF17E_CDCD, 30'h100},     // R5
    '{4'd10, 6'h22, 32'h400, 16'h0002, 1'b1, 4'h0, 32'h0, OLDV,          30'h100},     // R10
    '{4'd6,  6'h26, 32'h400, 16'h0003, 1'b0, 4'h0, 32'h0, 32'hBABA_932C, 30'h100},     // R6
    '{4'd10, 6'h26, 32'h400, 16'h0001, 1'b1, 4'h0, 32'h0, OLDV,          30'hFF},      // R10
    '{4'd10, 6'h26, 32'h400, 16'h0000, 1'b1, 4'h0, 32'h0, OLDV,          30'hFF},      // R10
    '{4'd7,  6'h28, 32'h500, 16'h0000, 1'b0, 4'h1, 32'hA900_0000, OLDV,  30'h140},     // R7
    '{4'd7,  6'h28, 32'h500, 16'h0003, 1'b0, 4'h8, 32'h0000_00A9, OLDV,  30'h140},     // R7
    '{4'd8,  6'h29, 32'h500, 16'h0000, 1'b0, 4'h3, 32'h56A9_0000, OLDV,  30'h140},     // R8
    '{4'd8,  6'h29, 32'h500, 16'h0002, 1'b0, 4'hC, 32'h0000_56A9, OLDV,  30'h140},     // R8
    '{4'd10, 6'h29, 32'h500, 16'h0003, 1'b1, 4'h0, 32'h0, OLDV,          30'h140},     // R10
    '{4'd9,  6'h2B, 32'h500, 16'h0000, 1'b0, 4'hF, STV,   OLDV,          30'h140},     // R9
    '{4'd10, 6'h2B, 32'h500, 16'h0001, 1'b1, 4'h0, 32'h0, OLDV,          30'h140},     // R10
    '{4'd12, 6'h3F, 32'h500, 16'h0001, 1'b0, 4'h0, 32'h0, OLDV,          30'h140},     // R12
    '{4'd11, 6'h28, 32'h1000_0001, 16'hFFFF, 1'b0, 4'h1, 32'hA900_0000, OLDV, 30'h0400_0000}, // R11
    '{4'd4,  6'h0F, 32'h1,   16'h0001, 1'b0, 4'h0, 32'h0, 32'h0001_0000, 30'h0}        // R4
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  opCode    = 6'h3F;
  logic [31:0] baseVal   = 32'h0;
  logic [15:0] offsetImm = 16'h0;
  logic [31:0] storeData = STV;
  logic [31:0] destOld   = OLDV;
  logic [31:0] memRdata  = MEMW;
  logic [29:0] wordAddr;
  logic [3:0]  byteEn;
  logic [31:0] wrData;
  logic [31:0] loadResult;
  logic        addrErr;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  be_mem_aligner dut (
    .opCode     (opCode),
    .baseVal    (baseVal),
    .offsetImm  (offsetImm),
    .storeData  (storeData),
    .destOld    (destOld),
    .memRdata   (memRdata),
    .wordAddr   (wordAddr),
    .byteEn     (byteEn),
    .wrData     (wrData),
    .loadResult (loadResult),
    .addrErr    (addrErr)
  );

  task automatic apply(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o);
    @(negedge clk);
    opCode    = op;
    baseVal   = b;
    offsetImm = o;
    #1;
  endtask

  task automatic checkAll(input string tag, input logic err, input logic [3:0] be,
                          input logic [31:0] wd, input logic [31:0] res, input logic [29:0] wa);
    testCnt++;
    if (addrErr !== err || byteEn !== be || wrData !== wd || loadResult !== res || wordAddr !== wa) begin
      failCnt++;
      $display("FAIL %s: got err=%0b be=%h wd=%h res=%h wa=%h, expected err=%0b be=%h wd=%h res=%h wa=%h",
               tag, addrErr, byteEn, wrData, loadResult, wordAddr, err, be, wd, res, wa);
    end
  endtask

  initial begin
    // quiescent state with an unlisted opcode: R12
    #1;
    checkAll("R12 idle", 1'b0, 4'h0, 32'h0, OLDV, 30'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].base, VECS[i].off);
      checkAll($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].err, VECS[i].be, VECS[i].wd, VECS[i].res, VECS[i].wa);
    end

    // R1 sweep: unsigned byte from every lane, expected from the lane rule
    for (int k = 0; k < 4; k++) begin
      apply(6'h24, 32'h0000_0800, 16'(k));
      checkAll($sformatf("R1 lane %0d", k), 1'b0, 4'h0, 32'h0,
               (MEMW >> (24 - 8 * k)) & 32'hFF, 30'h200);
    end

    // R7 sweep: byte store into every lane
    for (int k = 0; k < 4; k++) begin
      apply(6'h28, 32'h0000_0800, 16'(k));
      checkAll($sformatf("R7 lane %0d", k), 1'b0, 4'(1 << k),
               32'(STV[7:0]) << (24 - 8 * k), OLDV, 30'h200);
    end

    // R10 with a different old value: fault on a word store through a negative offset
    destOld = 32'h0F0F_A5A5;
    apply(6'h2B, 32'h0000_0900, 16'hFFFE);
    checkAll("R10 neg offset fault", 1'b1, 4'h0, 32'h0, 32'h0F0F_A5A5, 30'h23F);
    // R5 merge keeps new old value low half
    apply(6'h22, 32'h0000_0900, 16'hFFFC);
    checkAll("R5 merge new old", 1'b0, 4'h0, 32'h0, 32'hF17E_A5A5, 30'h23F);
    destOld = OLDV;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule